// File: doc/BRIEF.md
# Stereo Pulse-Density Output Stage with Source Mixer

This block converts PCM audio from two stereo serial ports into a single stereo pulse-density bitstream. It has four 16-bit signed inputs: left and right from port one, and left and right from port two. For each output channel, a four-bit select chooses any subset of these inputs. The selected samples are added together and clipped to the 16-bit range. The result drives a first-order delta-sigma modulator that emits one bit per step.

The output clock is the master clock divided by 4, 6 or 8, always with an equal high and low time. Both channels share one data wire. The left bit is refreshed one master cycle after each rising edge of the output clock, and the right bit one master cycle after each falling edge. A receiver can therefore latch left on the falling edge and right on the rising edge. Two 8-bit control words configure the block. The upper nibble of each word is that channel's mixer select. The lower nibble holds the channel enable and, in the left word only, the clock-rate code.

Top module: `pdm_stereo_out`

## Requirements
- R1: Rate code `ctrl_left_i[1:0]` sets the output clock period: 00 gives 8 master cycles, 01 gives 6 and 10 gives 4. Each high and each low phase lasts half the period.
- R2: Rate code 11 leaves the divider at the last valid code. Out of reset the divider runs at 8 master cycles.
- R3: The data line changes only one master cycle after an output-clock edge. After a rising edge it takes the new left bit, and after a falling edge the new right bit. Between those updates it holds its value.
- R4: Bit 3 of each control word enables that channel. While the bit is 0, the channel's slot on the data line is 0 and its accumulator is held at zero.
- R5: Mixer select bits 7, 6, 5 and 4 of each control word add port-one left, port-one right, port-two left and port-two right respectively. The selected inputs are summed as signed values.
- R6: A mixed sum above 32767 is clipped to 32767, and a sum below -32768 is clipped to -32768.
- R7: An all-zero select feeds the value 0. Starting from a cleared accumulator, this gives the alternating pattern 0,1,0,1 on that channel.
- R8: At each step, the modulator adds the sample plus 32768 to a 16-bit accumulator. The output bit is the carry out of that addition.
- R9: `ctrl_left_i[2]` and `ctrl_right_i[2:0]` have no effect on the output.
- R10: While reset is asserted, the output clock and the data line are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_left_i | input | 8 | Left mixer select [7:4], left enable [3], rate code [1:0] |
| ctrl_right_i | input | 8 | Right mixer select [7:4], right enable [3] |
| p1_left_i | input | 16 | Port-one left sample, signed |
| p1_right_i | input | 16 | Port-one right sample, signed |
| p2_left_i | input | 16 | Port-two left sample, signed |
| p2_right_i | input | 16 | Port-two right sample, signed |
| pdm_clk_o | output | 1 | Divided output clock |
| pdm_dat_o | output | 1 | Interleaved left/right pulse-density data |

## Verification
Two events can fall on the same master cycle. A channel's enable can drop exactly when that channel's step strobe fires. A write of a new or reserved rate code can arrive while the divider counter is partway through a phase. The bench switches enables and rate codes at phase boundaries wherever the counter happens to be, so both collisions arise across the sweep. It judges every output bit against a bit-exact arithmetic model. It checks each measured half period against the latched code, skipping only the two phases that follow a code change.

// File: rtl/pdm_out_pkg.sv
package pdm_out_pkg;
  localparam int unsigned HALF_W = 3;

  localparam logic [1:0] RATE_DIV8 = 2'b00;
  localparam logic [1:0] RATE_DIV6 = 2'b01;
  localparam logic [1:0] RATE_DIV4 = 2'b10;
  localparam logic [1:0] RATE_RSVD = 2'b11;

  // master cycles per output-clock phase for a valid rate code
  function automatic logic [HALF_W-1:0] half_of(input logic [1:0] code);
    case (code)
      RATE_DIV8: half_of = HALF_W'(4);
      RATE_DIV6: half_of = HALF_W'(3);
      default:   half_of = HALF_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
  import pdm_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_i,
  output logic       pdm_clk_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic [1:0]        rate_q, rate_d;
  logic [HALF_W-1:0] cnt_q, cnt_d, lim;
  logic              clk_q, clk_d;
  logic              rise_q, rise_d, fall_q, fall_d;
  logic              wrap;

  always_comb begin
    rate_d = (rate_i == RATE_RSVD) ? rate_q : rate_i;
    lim    = half_of(rate_q) - HALF_W'(1);
    wrap   = (cnt_q >= lim);
    cnt_d  = wrap ? '0 : cnt_q + HALF_W'(1);
    clk_d  = wrap ? ~clk_q : clk_q;
    rise_d = wrap & ~clk_q;
    fall_d = wrap & clk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= RATE_DIV8;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rate_q <= rate_d;
      cnt_q  <= cnt_d;
      clk_q  <= clk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign pdm_clk_o = clk_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;

  // R2: a reserved code never disturbs the latched rate
  p_rate_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == RATE_RSVD) |=> $stable(rate_q));
  // R3: left and right strobes never coincide
  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_q, fall_q}));
  // R3: the left strobe falls in the high phase, the right one in the low phase
  p_rise_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> clk_q);
  p_fall_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> !clk_q);
endmodule

// File: rtl/pdm_mixer.sv
module pdm_mixer #(
  parameter int unsigned W     = 16,
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0]        sel_i,
  input  logic [N_SRC-1:0][W-1:0] src_i,
  output logic [W-1:0]            mix_o
);
  localparam int unsigned SUM_W = W + $clog2(N_SRC);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** (W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -MAX_V - SUM_W'(1);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i[i]) sum = sum + $signed({{(SUM_W - W){src_i[i][W-1]}}, src_i[i]});
    end
    if (sum > MAX_V)      mix_o = MAX_V[W-1:0];
    else if (sum < MIN_V) mix_o = MIN_V[W-1:0];
    else                  mix_o = sum[W-1:0];
  end
endmodule

// File: rtl/pdm_dsm.sv
module pdm_dsm #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] sample_i,
  output logic         bit_o
);
  logic [W-1:0] acc_q, acc_d, offs;
  logic [W:0]   sum;

  always_comb begin
    offs  = {~sample_i[W-1], sample_i[W-2:0]};
    sum   = {1'b0, acc_q} + {1'b0, offs};
    bit_o = en_i & sum[W];
    if (!en_i)      acc_d = '0;
    else if (step_i) acc_d = sum[W-1:0];
    else            acc_d = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  // R8: the accumulator only moves on its own step
  p_acc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(acc_q));
  // R4: a disabled channel keeps a cleared accumulator
  p_acc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));
endmodule

// File: rtl/pdm_stereo_out.sv
module pdm_stereo_out #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          ctrl_left_i,
  input  logic [7:0]          ctrl_right_i,
  input  logic [SAMPLE_W-1:0] p1_left_i,
  input  logic [SAMPLE_W-1:0] p1_right_i,
  input  logic [SAMPLE_W-1:0] p2_left_i,
  input  logic [SAMPLE_W-1:0] p2_right_i,
  output logic                pdm_clk_o,
  output logic                pdm_dat_o
);
  localparam int unsigned N_SRC = 4;
  localparam int unsigned N_CH  = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N_CH-1:0][N_SRC-1:0]    sel;
  logic [N_CH-1:0]               en, step, ch_bit;
  logic [N_SRC-1:0][SAMPLE_W-1:0] srcs;
  logic [N_CH-1:0][SAMPLE_W-1:0] mix;
  logic                          rise, fall;
  logic                          dat_q, dat_d;
  logic                          unused_ctrl;

  assign sel         = {ctrl_right_i[7:4], ctrl_left_i[7:4]};
  assign en          = {ctrl_right_i[3], ctrl_left_i[3]};
  assign srcs        = {p1_left_i, p1_right_i, p2_left_i, p2_right_i};
  assign unused_ctrl = ^{ctrl_left_i[2], ctrl_right_i[2:0]};

  pdm_clk_gen u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .rate_i    (ctrl_left_i[1:0]),
    .pdm_clk_o (pdm_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  assign step = {fall, rise};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pdm_mixer #(.W(SAMPLE_W), .N_SRC(N_SRC)) u_mix (
      .sel_i (sel[ch]),
      .src_i (srcs),
      .mix_o (mix[ch])
    );
    pdm_dsm #(.W(SAMPLE_W)) u_dsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .en_i     (en[ch]),
      .step_i   (step[ch]),
      .sample_i (mix[ch]),
      .bit_o    (ch_bit[ch])
    );
    // R7: an empty selection feeds silence to the modulator
    p_silence_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sel[ch] == '0) |-> (mix[ch] == '0));
  end

  always_comb begin
    if (step[0])      dat_d = ch_bit[0];
    else if (step[1]) dat_d = ch_bit[1];
    else              dat_d = dat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dat_q <= 1'b0;
    else if (!rst_n) dat_q <= 1'b0;
    else            dat_q <= dat_d;
  end
  assign pdm_dat_o = dat_q;

  // R3: the data line holds between channel steps
  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|step) |=> $stable(pdm_dat_o));
  // R4: disabled slots are driven low
  p_left_off_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step[0] && !en[0]) |=> !pdm_dat_o);
  p_right_off_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step[1] && !en[1]) |=> !pdm_dat_o);
endmodule

// File: tb/test_pdm_stereo_out.sv
module test_pdm_stereo_out;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ctl_l, ctl_r;
  logic [15:0] s1l, s1r, s2l, s2r;
  logic        pclk, pdat;

  always #5 clk = ~clk;

  pdm_stereo_out i_pdm_stereo_out (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_left_i(ctl_l), .ctrl_right_i(ctl_r),
    .p1_left_i(s1l), .p1_right_i(s1r), .p2_left_i(s2l), .p2_right_i(s2r),
    .pdm_clk_o(pclk), .pdm_dat_o(pdat)
  );

  int checks = 0, fails = 0;
  int acc_l = 0, acc_r = 0;
  bit pend_l = 0, pend_r = 0, prev_clk = 0, exp_dat = 0, done = 0;
  int half_cnt = 0, settle = 1, exp_half = 4;
  int unsigned lfsr = 32'h1234_5678;
  string cur_req = "R5";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mix_of(input logic [3:0] sel);
    int s = 0;
    if (sel[3]) s += int'($signed(s1l));
    if (sel[2]) s += int'($signed(s1r));
    if (sel[1]) s += int'($signed(s2l));
    if (sel[0]) s += int'($signed(s2r));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic bit dsm_step(input bit en, input int smp, inout int acc);
    bit b;
    if (!en) begin
      acc = 0;
      return 1'b0;
    end
    acc = acc + smp + 32768;
    b   = acc[16];
    acc = acc & 32'hFFFF;
    return b;
  endfunction

  task automatic tick();
    @(negedge clk);
    if (pend_l) begin
      exp_dat = dsm_step(ctl_l[3], mix_of(ctl_l[7:4]), acc_l);
      pend_l  = 0;
    end else if (pend_r) begin
      exp_dat = dsm_step(ctl_r[3], mix_of(ctl_r[7:4]), acc_r);
      pend_r  = 0;
    end
    if (!ctl_l[3]) acc_l = 0;
    if (!ctl_r[3]) acc_r = 0;
    check(pdat === exp_dat, {"R3 R8 R9 data bit ", cur_req}, int'(pdat), int'(exp_dat));
    if (pclk !== prev_clk) begin
      if (settle > 0) settle--;
      else check(half_cnt == exp_half, "R1 R2 half period", half_cnt, exp_half);
      half_cnt = 1;
      if (pclk) pend_l = 1;
      else      pend_r = 1;
    end else begin
      half_cnt++;
    end
    prev_clk = pclk;
    lfsr = lfsr * 1103515245 + 12345;
    ctl_l[2]   = lfsr[16];   // R9: ignored bits toggled every cycle
    ctl_r[2:0] = lfsr[19:17];
  endtask

  task automatic run_phase(input logic [1:0] rate, input logic [3:0] sl, input logic [3:0] sr,
                           input bit el, input bit er, input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c, input logic [15:0] d, input int n, input string req);
    ctl_l[3] = 1'b0;
    ctl_r[3] = 1'b0;
    cur_req  = "R4";
    repeat (12) tick();
    s1l = a; s1r = b; s2l = c; s2r = d;
    ctl_l[7:4] = sl;
    ctl_r[7:4] = sr;
    if (ctl_l[1:0] != rate) begin
      ctl_l[1:0] = rate;
      settle = 2;
      if (rate == 2'b00) exp_half = 4;
      else if (rate == 2'b01) exp_half = 3;
      else if (rate == 2'b10) exp_half = 2;
    end
    ctl_l[3] = el;
    ctl_r[3] = er;
    cur_req  = req;
    repeat (n) tick();
  endtask

  initial begin
    rst_n = 1'b0;
    ctl_l = 8'h03;  // reserved rate from reset: R2 default divide by 8
    ctl_r = 8'h00;
    s1l = '0; s1r = '0; s2l = '0; s2r = '0;
    repeat (4) @(negedge clk);
    check(pclk === 1'b0, "R10 clock low in reset", int'(pclk), 0);
    check(pdat === 1'b0, "R10 data low in reset", int'(pdat), 0);
    rst_n = 1'b1;
    // R2: reserved code right after reset keeps 8-cycle period; R7 silence pattern
    run_phase(2'b11, 4'h0, 4'h0, 1, 1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 200, "R2 R7");
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < 16; s++) begin
        int idx = r * 16 + s;
        run_phase(2'(r), 4'(s), 4'(15 - s), 1, 1,
                  16'(idx * 7919 + 123), 16'(idx * 4099 ^ 16'h5a5a),
                  16'(idx * 30011 + 777), 16'(idx * 12007 ^ 16'h0f0f),
                  160, (s == 0) ? "R5 R7" : "R5");
      end
    end
    run_phase(2'b10, 4'hF, 4'hF, 1, 1, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 120, "R6 high");
    run_phase(2'b10, 4'hF, 4'hF, 1, 1, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 120, "R6 low");
    run_phase(2'b00, 4'hA, 4'h5, 1, 0, 16'h4000, 16'hC000, 16'h2000, 16'h1000, 200, "R4 left only");
    run_phase(2'b01, 4'h3, 4'hC, 0, 1, 16'h0100, 16'hF000, 16'h3000, 16'hE000, 200, "R4 right only");
    run_phase(2'b10, 4'h8, 4'h1, 1, 1, 16'h6000, 16'h0, 16'h0, 16'hA000, 100, "R1");
    run_phase(2'b11, 4'h8, 4'h1, 1, 1, 16'h6000, 16'h0, 16'h0, 16'hA000, 200, "R2 reserved");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule